// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

The block merges level-sensitive interrupt requests from a group of attached devices onto a few shared interrupt lines. Each device has four request pins. A change on a pin arrives as a request that names the device, the pin and the new level. The block keeps the last level it accepted for every device pin, so a request that repeats the current level has no effect. When a pin really changes, the block steers the change through a pin-to-line mapping and moves that line's counter up or down by one. A line is driven high while its counter is nonzero.

A parameter picks the mapping. The built-in rotation mode sends device d, pin p to line (p + d) mod NUM_LINES. The table mode reads a per-pin line index from an input vector, so the mapping can change while the block runs. If the mapping changes while a pin is high, that pin's later fall can land on a line that holds no count. In that case the counter stays at zero and a sticky error flag is raised. Each counter also stops at NUM_DEV*4. Interrupt controllers read the line levels directly, and the per-line counts are exposed for inspection.

Top module: `irq_line_aggregator`

## Requirements
- R1: A synchronous active-low reset clears every stored pin level, every line count and the error flag, so all lines are low. The request port shows not-ready while reset is held.
- R2: A request whose level equals the stored level of that device pin leaves every count and line unchanged.
- R3: A request that takes a stored pin level from 0 to 1 adds one to the count of the line that the pin maps to. No other line changes.
- R4: A request that takes a stored pin level from 1 to 0 subtracts one from the count of the mapped line.
- R5: Bit i of `line_out` is 1 exactly when the count of line i is nonzero.
- R6: With MAP_SEL = 0, device d, pin p maps to line (p + d) mod NUM_LINES.
- R7: With MAP_SEL = 1, device d, pin p maps to the line index held in `map_tbl` bits [(d*4+p)*LINE_W +: LINE_W], taken mod NUM_LINES. The mapping is sampled in the cycle the request is accepted.
- R8: `req_ready` stays high from the first cycle after reset, so one request is accepted every cycle. An accepted request shows in the counts after the next rising clock edge, and no count moves by more than one per cycle.
- R9: A fall routed to a line whose count is zero leaves that count at zero and sets `underflow_err`. The flag then stays set until reset.
- R10: A rise routed to a line whose count is already NUM_DEV*4 leaves that count at NUM_DEV*4.
- R11: While `req_valid` is low, no count, line or stored level changes, whatever the other request fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A pin-level request is presented |
| req_ready | output | 1 | The block accepts a request this cycle |
| req_dev | input | DEV_W | Index of the device that issues the request |
| req_pin | input | 2 | Pin number 0..3 within the device |
| req_level | input | 1 | New level of that pin |
| map_tbl | input | NUM_DEV*4*LINE_W | Per-pin line indexes, used when MAP_SEL = 1 |
| line_out | output | NUM_LINES | Shared line levels |
| line_count | output | NUM_LINES*CNT_W | Per-line counts, line i at [i*CNT_W +: CNT_W] |
| underflow_err | output | 1 | Sticky flag: a fall hit a line with a zero count |

## Verification
A wrong stored pin level shows up at the next request for that pin. A repeated level then moves a count when it should not, or a real change is dropped, so `line_count` differs one edge after acceptance. A counter that drifts shows in the count outputs in the cycle after the faulty update. Sweeping every device and pin in rise, repeat and fall order with both mappings makes a bad mapping entry, a missed step or a missing saturation show up in the next comparison. That comparison is made one cycle after each request.

// File: rtl/irq_agg_pkg.sv
// irq_agg_pkg
//   Shared constants and helpers for the shared interrupt line aggregator.
//   Assumes every device carries exactly four request pins.
package irq_agg_pkg;

    localparam int PINS_PER_DEV = 4;
    localparam int PIN_W        = 2;

    // Mapping variants selectable through the MAP_SEL parameter.
    typedef enum int {
        MAP_ROTATE = 0,
        MAP_TABLE  = 1
    } map_sel_e;

    // Index width for n items, never below one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irq_pin_store.sv
// irq_pin_store
//   Holds the last accepted level of every device pin. It flags an accepted
//   request as a rise or a fall only when the level differs from the stored
//   one. Assumes at most one request is accepted per cycle. Device indexes
//   outside NUM_DEV are ignored.
module irq_pin_store
    import irq_agg_pkg::*;
#(
    parameter int NUM_DEV = 4,
    parameter int DEV_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [DEV_W-1:0] dev,
    input  logic [PIN_W-1:0] pin,
    input  logic             level,
    output logic             rise,
    output logic             fall
);

    localparam int SLOTS = NUM_DEV * PINS_PER_DEV;
    localparam int IDX_W = DEV_W + PIN_W;

    logic [SLOTS-1:0] lvl_q;
    logic [IDX_W-1:0] slot;
    logic             in_range;
    logic             old_lvl;

    // Flat slot number of the addressed pin: dev*4 + pin.
    always_comb begin
        slot     = {dev, pin};
        in_range = (int'(dev) < NUM_DEV);
        old_lvl  = in_range ? lvl_q[slot] : 1'b0;
    end

    // Classify the request as a real rise, a real fall or no change.
    always_comb begin
        rise = accept && in_range &&  level && !old_lvl;
        fall = accept && in_range && !level &&  old_lvl;
    end

    // Record the accepted level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else if (accept && in_range) begin
            lvl_q[slot] <= level;
        end
    end

endmodule

// File: rtl/irq_line_map.sv
// irq_line_map
//   Combinational pin-to-line steering. MAP_SEL picks the variant. The
//   rotation sends (dev, pin) to (pin + dev) mod NUM_LINES. The table reads
//   a per-pin entry from map_tbl and takes it mod NUM_LINES.
//   Assumes dev < NUM_DEV for table lookups; other values select line 0.
module irq_line_map
    import irq_agg_pkg::*;
#(
    parameter int NUM_DEV   = 4,
    parameter int NUM_LINES = 4,
    parameter int MAP_SEL   = 0,
    parameter int DEV_W     = 2,
    parameter int LINE_W    = 2
) (
    input  logic [DEV_W-1:0]                        dev,
    input  logic [PIN_W-1:0]                        pin,
    input  logic [NUM_DEV*PINS_PER_DEV*LINE_W-1:0]  map_tbl,
    output logic [LINE_W-1:0]                       line
);

    generate
        if (MAP_SEL == MAP_ROTATE) begin : g_rotate
            logic [LINE_W-1:0] unused_tbl_xor;
            // Rotate the pin number by the device slot.
            always_comb begin
                line = LINE_W'((int'(dev) + int'(pin)) % NUM_LINES);
            end
            // Fold the unused table input so no input is left dangling.
            always_comb begin
                unused_tbl_xor = '0;
                for (int k = 0; k < NUM_DEV * PINS_PER_DEV; k++) begin
                    unused_tbl_xor = unused_tbl_xor ^ map_tbl[k*LINE_W +: LINE_W];
                end
            end
        end else begin : g_table
            int unsigned       base;
            logic [LINE_W-1:0] entry;
            // Look up the per-pin entry and fold it into the line range.
            always_comb begin
                base  = (int'(dev) * PINS_PER_DEV + int'(pin)) * LINE_W;
                entry = (int'(dev) < NUM_DEV) ? map_tbl[base +: LINE_W] : '0;
                line  = LINE_W'(int'(entry) % NUM_LINES);
            end
        end
    endgenerate

endmodule

// File: rtl/irq_line_counter.sv
// irq_line_counter
//   Up/down counter for one shared line. It counts how many sources drive
//   the line. It holds at 0 and at CNT_MAX and reports an attempted step
//   below zero. Assumes inc and dec are never both high in normal operation;
//   if they are, the two cancel.
module irq_line_counter #(
    parameter int CNT_W   = 5,
    parameter int CNT_MAX = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             active,
    output logic             underflow
);

    logic [CNT_W-1:0] cnt_q;
    logic             at_max;
    logic             at_zero;

    // Saturation limits.
    always_comb begin
        at_max  = (cnt_q == CNT_W'(CNT_MAX));
        at_zero = (cnt_q == '0);
    end

    // Step the count, holding at both limits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc && !dec && !at_max) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec && !inc && !at_zero) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Drive the count, the line level and the underflow pulse.
    always_comb begin
        count     = cnt_q;
        active    = !at_zero;
        underflow = dec && !inc && at_zero;
    end

endmodule

// File: rtl/irq_line_aggregator.sv
// irq_line_aggregator
//   Top of the shared interrupt line aggregator. It accepts one pin-level
//   request per cycle, detects real level changes, steers each change to a
//   shared line and keeps one counter per line. Line outputs show whether
//   each count is nonzero. Underflow attempts set a sticky flag.
//   Assumes a synchronous active-low reset, and that map_tbl is only read in
//   table mode.
module irq_line_aggregator
    import irq_agg_pkg::*;
#(
    parameter  int NUM_DEV   = 4,
    parameter  int NUM_LINES = 4,
    parameter  int MAP_SEL   = 0,
    localparam int DEV_W     = idx_width(NUM_DEV),
    localparam int LINE_W    = idx_width(NUM_LINES),
    localparam int CNT_MAX   = NUM_DEV * PINS_PER_DEV,
    localparam int CNT_W     = $clog2(CNT_MAX + 1),
    localparam int TBL_W     = NUM_DEV * PINS_PER_DEV * LINE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [DEV_W-1:0]           req_dev,
    input  logic [1:0]                 req_pin,
    input  logic                       req_level,
    input  logic [TBL_W-1:0]           map_tbl,
    output logic [NUM_LINES-1:0]       line_out,
    output logic [NUM_LINES*CNT_W-1:0] line_count,
    output logic                       underflow_err
);

    logic                 ready_q;
    logic                 accept;
    logic                 rise;
    logic                 fall;
    logic [LINE_W-1:0]    tgt_line;
    logic [NUM_LINES-1:0] uflow_vec;
    logic                 err_q;

    // The request port opens one cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else begin
            ready_q <= 1'b1;
        end
    end

    // Handshake completion.
    always_comb begin
        req_ready = ready_q;
        accept    = req_valid && ready_q;
    end

    irq_pin_store #(
        .NUM_DEV (NUM_DEV),
        .DEV_W   (DEV_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .dev    (req_dev),
        .pin    (req_pin),
        .level  (req_level),
        .rise   (rise),
        .fall   (fall)
    );

    irq_line_map #(
        .NUM_DEV   (NUM_DEV),
        .NUM_LINES (NUM_LINES),
        .MAP_SEL   (MAP_SEL),
        .DEV_W     (DEV_W),
        .LINE_W    (LINE_W)
    ) u_map (
        .dev     (req_dev),
        .pin     (req_pin),
        .map_tbl (map_tbl),
        .line    (tgt_line)
    );

    generate
        for (genvar li = 0; li < NUM_LINES; li++) begin : g_line
            logic hit;
            // Does this change target line li?
            always_comb begin
                hit = (int'(tgt_line) == li);
            end

            irq_line_counter #(
                .CNT_W   (CNT_W),
                .CNT_MAX (CNT_MAX)
            ) u_cnt (
                .clk       (clk),
                .rst_n     (rst_n),
                .inc       (rise && hit),
                .dec       (fall && hit),
                .count     (line_count[li*CNT_W +: CNT_W]),
                .active    (line_out[li]),
                .underflow (uflow_vec[li])
            );
        end
    endgenerate

    // Latch any underflow attempt until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (|uflow_vec) begin
            err_q <= 1'b1;
        end
    end

    // Drive the sticky flag.
    always_comb begin
        underflow_err = err_q;
    end

endmodule

// File: rtl/irq_agg_checker.sv
// irq_agg_checker
//   Temporal properties of the aggregator, observed at its ports. Attached
//   to every instance through the bind statement at the end of this file.
module irq_agg_checker #(
    parameter int NUM_LINES = 4,
    parameter int CNT_W     = 5,
    parameter int CNT_MAX   = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic [NUM_LINES-1:0]       line_out,
    input logic [NUM_LINES*CNT_W-1:0] line_count,
    input logic                       underflow_err
);

    // R8
    ready_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> req_ready);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(req_valid)) |-> $stable(line_count));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(underflow_err)) |-> underflow_err);

    // R8
    one_line_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(line_out ^ $past(line_out)) <= 1));

    generate
        for (genvar li = 0; li < NUM_LINES; li++) begin : g_chk
            // R10
            cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                line_count[li*CNT_W +: CNT_W] <= CNT_W'(CNT_MAX));

            // R8
            unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |->
                ((line_count[li*CNT_W +: CNT_W] == $past(line_count[li*CNT_W +: CNT_W])) ||
                 (line_count[li*CNT_W +: CNT_W] == $past(line_count[li*CNT_W +: CNT_W]) + 1'b1) ||
                 (line_count[li*CNT_W +: CNT_W] + 1'b1 == $past(line_count[li*CNT_W +: CNT_W]))));
        end
    endgenerate

endmodule

bind irq_line_aggregator irq_agg_checker #(
    .NUM_LINES (NUM_LINES),
    .CNT_W     (CNT_W),
    .CNT_MAX   (CNT_MAX)
) u_irq_agg_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .line_out      (line_out),
    .line_count    (line_count),
    .underflow_err (underflow_err)
);

// File: tb/test_irq_line_aggregator.sv
// test_irq_line_aggregator
//   Drives one rotation-mapped and one table-mapped instance with the same
//   request stream and compares both against arithmetic models.
module test_irq_line_aggregator;

    localparam int CLK_PERIOD = 10;
    localparam int ND   = 4;
    localparam int NL   = 4;
    localparam int LW   = 2;
    localparam int CW   = 5;
    localparam int CMAX = ND * 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_dev = '0;
    logic [1:0]        req_pin = '0;
    logic              req_level = 1'b0;
    logic [ND*4*LW-1:0] tbl = '0;

    logic              rdy_a, rdy_b, err_a, err_b;
    logic [NL-1:0]     line_a, line_b;
    logic [NL*CW-1:0]  cnt_a, cnt_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    bit lvl_m [ND][4];
    int m_a [NL];
    int m_b [NL];
    bit e_a, e_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_line_aggregator #(.NUM_DEV(ND), .NUM_LINES(NL), .MAP_SEL(0)) i_irq_line_aggregator (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_a),
        .req_dev(req_dev), .req_pin(req_pin), .req_level(req_level), .map_tbl(tbl),
        .line_out(line_a), .line_count(cnt_a), .underflow_err(err_a));

    irq_line_aggregator #(.NUM_DEV(ND), .NUM_LINES(NL), .MAP_SEL(1)) i_irq_line_aggregator_tbl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_b),
        .req_dev(req_dev), .req_pin(req_pin), .req_level(req_level), .map_tbl(tbl),
        .line_out(line_b), .line_count(cnt_b), .underflow_err(err_b));

    task automatic check(input string rq, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Compare every count, line and flag of both instances with the models (R5).
    task automatic compare_all(input string rq);
        for (int l = 0; l < NL; l++) begin
            check({rq, " rot count"}, int'(cnt_a[l*CW +: CW]), m_a[l]);
            check({rq, " tbl count"}, int'(cnt_b[l*CW +: CW]), m_b[l]);
            check({rq, " R5 rot line"}, int'(line_a[l]), int'(m_a[l] != 0));
            check({rq, " R5 tbl line"}, int'(line_b[l]), int'(m_b[l] != 0));
        end
        check({rq, " rot err"}, int'(err_a), int'(e_a));
        check({rq, " tbl err"}, int'(err_b), int'(e_b));
    endtask

    task automatic model_step(input int d, input int p, input bit lv);
        int la, lb;
        if (lv == lvl_m[d][p]) return;
        la = (d + p) % NL;
        lb = int'(tbl[(d*4+p)*LW +: LW]) % NL;
        lvl_m[d][p] = lv;
        if (lv) begin
            if (m_a[la] < CMAX) m_a[la]++;
            if (m_b[lb] < CMAX) m_b[lb]++;
        end else begin
            if (m_a[la] == 0) e_a = 1'b1; else m_a[la]--;
            if (m_b[lb] == 0) e_b = 1'b1; else m_b[lb]--;
        end
    endtask

    // One accepted request: drive at a falling edge, sample at the next one.
    task automatic apply(input int d, input int p, input bit lv, input string rq);
        req_valid = 1'b1;
        req_dev   = 2'(d);
        req_pin   = 2'(p);
        req_level = lv;
        model_step(d, p, lv);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        compare_all(rq);
    endtask

    task automatic model_reset();
        for (int d = 0; d < ND; d++)
            for (int p = 0; p < 4; p++) lvl_m[d][p] = 1'b0;
        for (int l = 0; l < NL; l++) begin m_a[l] = 0; m_b[l] = 0; end
        e_a = 1'b0;
        e_b = 1'b0;
    endtask

    task automatic set_entry(input int d, input int p, input int l);
        tbl[(d*4+p)*LW +: LW] = 2'(l);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] lfsr;
        for (int d = 0; d < ND; d++)
            for (int p = 0; p < 4; p++) set_entry(d, p, (3 * d + 2 * p + 1) % NL);
        model_reset();

        // R1: reset state and ready
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all("R1");
        check("R1 ready in reset", int'(rdy_a), 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R8 ready rot", int'(rdy_a), 1);
        check("R8 ready tbl", int'(rdy_b), 1);

        // R3 R6 R7: rise sweep over every device pin
        for (int d = 0; d < ND; d++)
            for (int p = 0; p < 4; p++) apply(d, p, 1'b1, "R3 R6 R7 rise");

        // R2: repeated levels
        apply(2, 1, 1'b1, "R2 repeat high");
        apply(0, 3, 1'b1, "R2 repeat high");

        // R4: fall sweep in reverse order
        for (int d = ND - 1; d >= 0; d--)
            for (int p = 3; p >= 0; p--) apply(d, p, 1'b0, "R4 fall");
        apply(1, 2, 1'b0, "R2 repeat low");

        // R11: idle cycles with busy request fields
        req_dev = 2'd3; req_pin = 2'd2; req_level = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all("R11 idle");
        apply(3, 2, 1'b1, "R11 then accept");

        // R8: back-to-back pseudo-random stream
        lfsr = 8'hA5;
        for (int k = 0; k < 80; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            apply(int'(lfsr[1:0]), int'(lfsr[3:2]), lfsr[6], "R8 stream");
        end

        // clear all pins
        for (int d = 0; d < ND; d++)
            for (int p = 0; p < 4; p++) apply(d, p, 1'b0, "R4 clear");
        check("R9 no error yet", int'(err_b), 0);

        // R9: remap a high pin onto an empty line, then drop it
        set_entry(0, 0, 0);
        apply(0, 0, 1'b1, "R9 setup");
        set_entry(0, 0, 2);
        apply(0, 0, 1'b0, "R9 underflow");
        check("R9 err set", int'(err_b), 1);
        check("R9 line2 held at zero", int'(cnt_b[2*CW +: CW]), 0);
        apply(1, 1, 1'b1, "R9 err stays");

        // R10: pump one line past its cap with remapping
        for (int k = 0; k < CMAX + 4; k++) begin
            set_entry(1, 0, 0);
            apply(1, 0, 1'b1, "R10 pump");
            set_entry(1, 0, 3);
            apply(1, 0, 1'b0, "R10 pump");
        end
        check("R10 cap", int'(cnt_b[0 +: CW]), CMAX);

        // R1: reset in mid-run
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        model_reset();
        compare_all("R1 mid reset");
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        apply(2, 3, 1'b1, "R1 after reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule